// File: doc/BRIEF.md
# C-Slow Recirculating Random-Walk Path Scheduler

This block is the core loop of a Monte-Carlo path engine. One state-transition pipeline of fixed depth L carries L independent random-walk paths at once, one per pipeline slot. Every clock in which the loop advances, the state at the pipeline tail is tested against the programmed step limit T:

- A path still short of T re-enters the pipeline head in its own slot.
- A finished path has its final level written to a terminal-result FIFO. In the same cycle a fresh initial state (x = x0, t = 0) takes over that slot, so no slot sits idle while paths remain to be started.

The transition is a plain random walk. Each step adds a signed 16-bit noise sample from an internal Galois LFSR to the level and adds one to the step counter. A batch is set up through static inputs and then started with a one-cycle pulse: initial level, step limit, path budget and LFSR seed. The block launches exactly the budgeted number of paths and then drains. Results leave through a show-ahead FIFO read port. When the result FIFO is full and another path finishes, the whole loop freezes for that cycle, so no result is ever dropped. A stop pulse abandons the paths still in flight.

Top module: `cslow_path_sched`

## Requirements
- R1: After reset, busy_o=0, done_o=1 and empty_o=1.
- R2: In idle, a start_i pulse captures x0_i, t_end_i (T, which must be at least 1), budget_i and seed_i, and busy_o is 1 from the next cycle. Later changes of those inputs, and start_i pulses while busy, do not affect the running batch.
- R3: Noise comes from a 32-bit right-shifting Galois LFSR with XOR mask 32'h80200003, applied when the bit shifted out is 1. The LFSR is loaded at start with the seed, or with 1 if the seed is zero. The noise sample R is the LFSR's low 16 bits read as a signed value. The LFSR advances exactly once per loop advance.
- R4: In each loop advance, the state entering the pipeline head becomes x' = x + R and t' = t + 1, using the current R. It reaches the tail L = 8 advances later. Slots therefore rotate in a fixed order, and advance k of a batch serves slot k mod 8.
- R5: A valid tail state with t equal to T is pushed into the result FIFO as its 32-bit x. A valid tail state with t different from T re-enters the head unchanged.
- R6: A slot freed by a finished path, or empty at batch start, receives the initial state (x0, 0) while fewer than budget paths have been launched in this batch; otherwise the slot stays empty.
- R7: The result FIFO holds 16 entries in arrival order. When empty_o is 0, rd_data_o shows the oldest entry and rd_en_i removes it. rd_en_i while empty_o is 1 is ignored.
- R8: If a finished path reaches the tail while the FIFO is full, the loop does not advance in that cycle: no pipeline, LFSR or counter change. No result is lost.
- R9: The batch ends, and busy_o falls, once all budgeted paths have been launched and no slot holds a path. done_o equals (not busy) and empty_o.
- R10: A stop_i pulse while busy returns to idle in the next cycle and discards in-flight paths. Results already in the FIFO are kept.
- R11: A batch with a budget of 0 produces no result and ends within two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, captures batch settings |
| stop_i | input | 1 | Abort pulse |
| x0_i | input | 32 | Initial path level |
| t_end_i | input | 16 | Step count T at which a path ends |
| budget_i | input | 16 | Number of paths to launch |
| seed_i | input | 32 | LFSR seed |
| rd_en_i | input | 1 | Remove oldest result |
| rd_data_o | output | 32 | Oldest result (final x) |
| empty_o | output | 1 | Result FIFO empty |
| busy_o | output | 1 | Batch running |
| done_o | output | 1 | Idle with no unread result |

## Verification
The bench carries its own step-level model of the slot rotation and the noise sequence, and compares every result in order. Batches with a budget below L show that unused slots stay empty. Batches with a budget well above L show refill on the same advance as a path finishes. Batches with T = 1 and with longer T separate the immediate-exit case from the recirculation case. A run with no reads fills the FIFO and proves the stall loses nothing and keeps the noise sequence aligned. Directed cases cover input changes and a second start during a run, an abort, a zero seed and a zero budget.

// File: rtl/cslow_pkg.sv
package cslow_pkg;
  localparam int XW = 32;
  localparam int TW = 16;
  localparam int LW = 32;
  localparam logic [LW-1:0] LFSR_MASK = 32'h80200003;

  typedef struct packed {
    logic          v;
    logic [XW-1:0] x;
    logic [TW-1:0] t;
  } slot_t;

  function automatic logic [LW-1:0] lfsr_step(input logic [LW-1:0] s);
    return s[0] ? ((s >> 1) ^ LFSR_MASK) : (s >> 1);
  endfunction
endpackage

// File: rtl/lfsr_noise.sv
module lfsr_noise
  import cslow_pkg::*;
#(
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] seed,
  input  logic          en,
  output logic [RW-1:0] noise
);
  logic [LW-1:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (load)    state_d = (seed == '0) ? LW'(1) : seed;
    else if (en) state_d = lfsr_step(state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LW'(1);
    else        state_q <= state_d;
  end

  assign noise = state_q[RW-1:0];

  // R3
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  // R8
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !en) |=> $stable(state_q));
endmodule

// File: rtl/walk_pipe.sv
module walk_pipe
  import cslow_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int RW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          flush,
  input  slot_t         head,
  input  logic [RW-1:0] noise,
  output slot_t         tail
);
  slot_t stage_q [DEPTH];
  slot_t stage_d [DEPTH];
  slot_t stepped;

  always_comb begin
    stepped.v = head.v;
    stepped.x = head.x + {{(XW-RW){noise[RW-1]}}, noise};
    stepped.t = head.t + TW'(1);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_comb begin
      stage_d[i] = stage_q[i];
      if (flush)   stage_d[i] = '0;
      else if (en) stage_d[i] = (i == 0) ? stepped : stage_q[(i == 0) ? 0 : i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= '0;
      else        stage_q[i] <= stage_d[i];
    end
  end

  assign tail = stage_q[DEPTH-1];

  // R8
  pipe_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !flush) |=> $stable(tail));
  // R10
  pipe_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !tail.v);
endmodule

// File: rtl/term_fifo.sv
module term_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q, wr_d, rd_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          do_pop;

  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == DEPTH_C);
  assign do_pop = pop && !empty;
  assign dout   = mem_q[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push)   wr_d = (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + AW'(1);
    if (do_pop) rd_d = (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + AW'(1);
    if (push && !do_pop)      cnt_d = cnt_q + (AW+1)'(1);
    else if (!push && do_pop) cnt_d = cnt_q - (AW+1)'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= din;
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> empty);
endmodule

// File: rtl/cslow_path_sched.sv
module cslow_path_sched
  import cslow_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int RW      = 16,
  parameter int BW      = 16,
  parameter int FIFO_DP = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [31:0]   x0_i,
  input  logic [15:0]   t_end_i,
  input  logic [15:0]   budget_i,
  input  logic [31:0]   seed_i,
  input  logic          rd_en_i,
  output logic [31:0]   rd_data_o,
  output logic          empty_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int IW = $clog2(DEPTH + 1);
  localparam logic [IW-1:0] DEPTH_C = IW'(DEPTH);

  typedef enum logic {S_IDLE, S_RUN} run_e;

  run_e          state_q, state_d;
  logic [XW-1:0] cfg_x0_q;
  logic [TW-1:0] cfg_t_q;
  logic [BW-1:0] cfg_bud_q, launched_q, launched_d;
  logic [IW-1:0] inflight_q, inflight_d;

  slot_t         head, tail;
  logic [RW-1:0] noise;
  logic          run, accept, advance, tail_done, tail_back, launch, push, finish, flush, full;

  assign run       = (state_q == S_RUN);
  assign accept    = !run && start_i;
  assign tail_done = tail.v && (tail.t == cfg_t_q);
  assign tail_back = tail.v && !tail_done;
  assign advance   = run && !stop_i && !(tail_done && full);
  assign launch    = advance && !tail_back && (launched_q < cfg_bud_q);
  assign push      = advance && tail_done;
  assign finish    = run && (launched_q == cfg_bud_q) && (inflight_q == '0);
  assign flush     = run && stop_i;

  always_comb begin
    if (tail_back) head = tail;
    else           head = '{v: (launched_q < cfg_bud_q), x: cfg_x0_q, t: '0};
  end

  always_comb begin
    state_d    = state_q;
    launched_d = launched_q;
    inflight_d = inflight_q;
    if (accept) begin
      state_d    = S_RUN;
      launched_d = '0;
      inflight_d = '0;
    end else if (flush) begin
      state_d    = S_IDLE;
      inflight_d = '0;
    end else if (finish) begin
      state_d = S_IDLE;
    end else if (advance) begin
      if (launch) launched_d = launched_q + BW'(1);
      if (launch && !push)      inflight_d = inflight_q + IW'(1);
      else if (!launch && push) inflight_d = inflight_q - IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      launched_q <= '0;
      inflight_q <= '0;
      cfg_x0_q   <= '0;
      cfg_t_q    <= '0;
      cfg_bud_q  <= '0;
    end else begin
      state_q    <= state_d;
      launched_q <= launched_d;
      inflight_q <= inflight_d;
      if (accept) begin
        cfg_x0_q  <= x0_i;
        cfg_t_q   <= t_end_i;
        cfg_bud_q <= budget_i;
      end
    end
  end

  lfsr_noise #(.RW(RW)) u_noise (
    .clk(clk), .rst_n(rst_n), .load(accept), .seed(seed_i), .en(advance), .noise(noise)
  );

  walk_pipe #(.DEPTH(DEPTH), .RW(RW)) u_pipe (
    .clk(clk), .rst_n(rst_n), .en(advance), .flush(flush),
    .head(head), .noise(noise), .tail(tail)
  );

  term_fifo #(.DW(XW), .DEPTH(FIFO_DP)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(tail.x), .pop(rd_en_i),
    .dout(rd_data_o), .empty(empty_o), .full(full)
  );

  assign busy_o = run;
  assign done_o = !run && empty_o;

  // R6
  inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q <= DEPTH_C);
  // R6
  launch_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (launched_q <= cfg_bud_q));
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);
  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && stop_i) |=> !busy_o);
  // R9
  done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> empty_o);
  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) && run |-> $stable(cfg_t_q) && $stable(cfg_x0_q));
endmodule

// File: tb/cslow_path_sched_tb.sv
module cslow_path_sched_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0, rd_en_i = 1'b0;
  logic [31:0] x0_i = '0, seed_i = '0;
  logic [15:0] t_end_i = '0, budget_i = '0;
  logic [31:0] rd_data_o;
  logic        empty_o, busy_o, done_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [31:0] exp_q[$];

  always #4 clk = ~clk;

  cslow_path_sched dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .x0_i(x0_i), .t_end_i(t_end_i), .budget_i(budget_i), .seed_i(seed_i),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .empty_o(empty_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 190000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lfsr_adv(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ 32'h80200003) : (s >> 1);
  endfunction

  // Step-level model of R3..R6: slot k mod 8 is served at advance k
  task automatic build_expected(input logic [31:0] x0, input logic [15:0] tt,
                                input logic [15:0] bud, input logic [31:0] sd);
    logic        v [8];
    logic [31:0] xs [8];
    logic [15:0] ts [8];
    logic [31:0] lf;
    int          launched, inflight;
    exp_q.delete();
    for (int i = 0; i < 8; i++) begin v[i] = 1'b0; xs[i] = '0; ts[i] = '0; end
    lf = (sd == 0) ? 32'h1 : sd;
    launched = 0;
    inflight = 0;
    for (int k = 0; k < 2000000; k++) begin
      int          s;
      logic        hv;
      logic [31:0] hx;
      logic [15:0] ht;
      if (launched == int'(bud) && inflight == 0) break;
      s = k % 8;
      if (v[s] && ts[s] != tt) begin
        hv = 1'b1; hx = xs[s]; ht = ts[s];
      end else begin
        if (v[s]) begin exp_q.push_back(xs[s]); inflight--; end
        hv = (launched < int'(bud)); hx = x0; ht = '0;
        if (hv) begin launched++; inflight++; end
      end
      v[s]  = hv;
      xs[s] = hx + {{16{lf[15]}}, lf[15:0]};
      ts[s] = ht + 16'd1;
      lf    = lfsr_adv(lf);
    end
  endtask

  task automatic pulse_start(input logic [31:0] x0, input logic [15:0] tt,
                             input logic [15:0] bud, input logic [31:0] sd);
    @(negedge clk);
    x0_i = x0; t_end_i = tt; budget_i = bud; seed_i = sd;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic read_all(input string req);
    int n = exp_q.size();
    for (int i = 0; i < n; i++) begin
      int w = 0;
      while (empty_o && w < 20000) begin @(negedge clk); w++; end
      check(req, rd_data_o, exp_q[i]);
      rd_en_i = 1'b1;
      @(negedge clk);
      rd_en_i = 1'b0;
    end
  endtask

  task automatic wait_done(input string req);
    int w = 0;
    while (!done_o && w < 3000) begin @(negedge clk); w++; end
    check(req, {29'd0, done_o, busy_o, empty_o}, 32'h5);
  endtask

  task automatic run_batch(input string req, input logic [31:0] x0, input logic [15:0] tt,
                           input logic [15:0] bud, input logic [31:0] sd);
    build_expected(x0, tt, bud, sd);
    pulse_start(x0, tt, bud, sd);
    check("R2 busy after start", {31'd0, busy_o}, 32'd1);
    read_all(req);
    wait_done("R9 done after drain");
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset done/busy/empty", {29'd0, done_o, busy_o, empty_o}, 32'h5);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {29'd0, done_o, busy_o, empty_o}, 32'h5);

    // R4 R5 R6: budget above slot count, several steps per path
    run_batch("R4 R5 walk T=5 budget=20", 32'h0000_1000, 16'd5, 16'd20, 32'hACE1_2345);
    // R6: budget below slot count, one step per path
    run_batch("R6 budget=3 T=1", 32'hFFFF_FF00, 16'd1, 16'd3, 32'h1357_9BDF);
    // R3: zero seed replaced by 1
    run_batch("R3 zero seed", 32'd0, 16'd3, 16'd10, 32'd0);

    // R8: no reads, FIFO fills and loop stalls
    build_expected(32'h0000_0100, 16'd2, 16'd40, 32'h0BAD_F00D);
    pulse_start(32'h0000_0100, 16'd2, 16'd40, 32'h0BAD_F00D);
    repeat (1000) @(negedge clk);
    check("R8 stalled batch still busy", {30'd0, busy_o, empty_o}, 32'h2);
    read_all("R8 no result lost");
    wait_done("R8 done after stall");

    // R2: input changes and second start while busy are ignored
    build_expected(32'h0000_5555, 16'd4, 16'd12, 32'h2222_1111);
    pulse_start(32'h0000_5555, 16'd4, 16'd12, 32'h2222_1111);
    repeat (5) @(negedge clk);
    pulse_start(32'h7777_0000, 16'd9, 16'd30, 32'h9999_8888);
    x0_i = 32'h1234_0000; t_end_i = 16'd2; budget_i = 16'd1;
    read_all("R2 running batch unaffected");
    wait_done("R2 done");

    // R10: stop discards in-flight paths
    pulse_start(32'h0, 16'd50, 16'd100, 32'h5A5A_5A5A);
    repeat (20) @(negedge clk);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    check("R10 idle after stop", {29'd0, done_o, busy_o, empty_o}, 32'h5);
    repeat (20) @(negedge clk);
    check("R10 no late result", {31'd0, empty_o}, 32'd1);

    // R11: zero budget
    pulse_start(32'h0, 16'd3, 16'd0, 32'h1);
    @(negedge clk);
    check("R11 zero budget ends", {29'd0, done_o, busy_o, empty_o}, 32'h5);

    // R4 R5 R6 after stop: randomized batches
    for (int b = 0; b < 6; b++) begin
      logic [31:0] rx0 = $urandom;
      logic [15:0] rt  = 16'($urandom_range(12, 1));
      logic [15:0] rb  = 16'($urandom_range(40, 1));
      logic [31:0] rs  = $urandom;
      run_batch("R5 random batch", rx0, rt, rb, rs);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule